// File: doc/BRIEF.md
# Runahead Usefulness Gate

This block decides whether a long-latency load that has reached the head of the window may start a runahead period. The caller presents the load's PC together with a "never" bit from an offline profile. In the same cycle the block answers with a single allow bit. The answer combines three things:

- a direct-mapped table of 2-bit saturating confidence counters, indexed by the load PC;
- a phase filter that, after a window of periods which brought too few misses, refuses a fixed number of later opportunities;
- the profile veto.

When a runahead period ends, the caller sends one training pulse. The pulse carries the triggering load's PC, a bit that says whether the period was useful, and the number of misses the period produced. A period is useful when at least one of its misses lay beyond the reach of the normal instruction window. The caller makes that judgement; the block does not.

Top module: `ra_useful_gate`

## Requirements
- R1: The table entry is selected by PC bits [ALIGN+IDX_W-1:ALIGN] (bits 7:2 by default). Two PCs that agree in those bits share one counter.
- R2: After reset every counter holds binary 10 and the skip count is zero. A query from any PC with the profile bit clear is then allowed.
- R3: A counter moves up by one on a useful training pulse and down by one on a useless one. It saturates at 11 and at 00. The counter predicts "useful" when its upper bit is 1.
- R4: `allow` is high only when all of these hold: `query_valid` is high, the indexed counter predicts useful, the skip count is zero, and `query_never` is low. It is combinational in the cycle of the query.
- R5: A query with `query_never` high is never allowed, whatever the counter and filter state.
- R6: Every WIN_N training pulses form a window. On the last pulse of a window, the sum of `train_misses` over the window (that pulse included) is compared with MISS_T. If the sum is below MISS_T, the skip count is loaded with SKIP_M. A sum equal to or above MISS_T loads nothing.
- R7: While the skip count is non-zero, each query cycle lowers it by one. Training pulses do not lower it. The SKIP_M-th query after a failed window is still refused, and the next one is judged normally.
- R8: When a training pulse and a query address the same entry in the same cycle, the query sees the counter value from before that pulse.
- R9: When a failing window closes in the same cycle as a query, the skip count is loaded with SKIP_M and is not decremented by that query.
- R10: A training pulse changes the outcome of queries from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| query_valid | input | 1 | A runahead opportunity is being considered this cycle |
| query_pc | input | PC_W | PC of the load that would trigger runahead |
| query_never | input | 1 | Profile mark: this load must never trigger runahead |
| allow | output | 1 | Runahead may be entered for this opportunity |
| train_valid | input | 1 | One-cycle pulse when a runahead period ends |
| train_pc | input | PC_W | PC of the load that triggered the finished period |
| train_useful | input | 1 | The finished period was useful |
| train_misses | input | MISS_W | Number of misses produced by the finished period |

## Verification
The query answer is combinational, so it is due in the same cycle as `query_valid`. The bench drives each step at the falling edge and samples `allow` one nanosecond later, before the next rising edge. A training pulse, a window close or a skip load acts only on the next rising edge. Every check that depends on such an update is therefore placed at least one step after the pulse that causes it. The same-cycle cases (R8, R9) are checked in the cycle of the collision and again in the cycles after it.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'b10;

    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t r;
        r = c;
        if (up) begin
            if (c != 2'b11) r = c + 2'b01;
        end else begin
            if (c != 2'b00) r = c - 2'b01;
        end
        return r;
    endfunction
endpackage

// File: rtl/ra_pred_table.sv
module ra_pred_table
    import ra_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int ALIGN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_useful,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_up
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        ctr2_t [ENTRIES-1:0] ctr;
    } tbl_t;

    tbl_t              st_d, st_q;
    logic [IDX_W-1:0]  rd_idx, wr_idx;

    assign rd_idx    = rd_pc[ALIGN +: IDX_W];
    assign wr_idx    = wr_pc[ALIGN +: IDX_W];
    assign rd_useful = st_q.ctr[rd_idx][1];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctr <= {ENTRIES{CTR_RESET}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ra_phase_filter.sv
module ra_phase_filter #(
    parameter int MISS_W = 8,
    parameter int WIN_N  = 4,
    parameter int MISS_T = 3,
    parameter int SKIP_M = 5,
    localparam int SKIP_W = $clog2(SKIP_M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tr_valid,
    input  logic [MISS_W-1:0] tr_misses,
    input  logic              opp_valid,
    output logic [SKIP_W-1:0] skip_cnt,
    output logic              win_fail,
    output logic              quiet
);
    localparam int CNT_W = $clog2(WIN_N + 1);
    localparam int SUM_W = MISS_W + CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SUM_W-1:0]  sum;
        logic [SKIP_W-1:0] skip;
    } flt_t;

    flt_t             st_d, st_q;
    logic [SUM_W-1:0] sum_now;
    logic             last;

    always_comb begin
        st_d     = st_q;
        sum_now  = st_q.sum + SUM_W'(tr_misses);
        last     = (st_q.cnt == CNT_W'(WIN_N - 1));
        win_fail = tr_valid && last && (sum_now < SUM_W'(MISS_T));
        if (opp_valid && st_q.skip != '0) begin
            st_d.skip = st_q.skip - SKIP_W'(1);
        end
        if (tr_valid) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.sum = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.sum = sum_now;
            end
        end
        if (win_fail) begin
            st_d.skip = SKIP_W'(SKIP_M);
        end
    end

    assign skip_cnt = st_q.skip;
    assign quiet    = (st_q.skip == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ra_useful_gate.sv
module ra_useful_gate #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 6,
    parameter int ALIGN  = 2,
    parameter int MISS_W = 8,
    parameter int WIN_N  = 4,
    parameter int MISS_T = 3,
    parameter int SKIP_M = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              query_valid,
    input  logic [PC_W-1:0]   query_pc,
    input  logic              query_never,
    output logic              allow,
    input  logic              train_valid,
    input  logic [PC_W-1:0]   train_pc,
    input  logic              train_useful,
    input  logic [MISS_W-1:0] train_misses
);
    localparam int SKIP_W = $clog2(SKIP_M + 1);

    logic              pred_useful;
    logic              quiet;
    logic              win_fail;
    logic [SKIP_W-1:0] skip_cnt;

    ra_pred_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (query_pc),
        .rd_useful (pred_useful),
        .wr_en     (train_valid),
        .wr_pc     (train_pc),
        .wr_up     (train_useful)
    );

    ra_phase_filter #(.MISS_W(MISS_W), .WIN_N(WIN_N), .MISS_T(MISS_T), .SKIP_M(SKIP_M)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tr_valid  (train_valid),
        .tr_misses (train_misses),
        .opp_valid (query_valid),
        .skip_cnt  (skip_cnt),
        .win_fail  (win_fail),
        .quiet     (quiet)
    );

    assign allow = query_valid && pred_useful && quiet && !query_never;
endmodule

// File: rtl/ra_useful_gate_chk.sv
module ra_useful_gate_chk #(
    parameter int SKIP_M = 5,
    parameter int SKIP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              query_valid,
    input logic              query_never,
    input logic              allow,
    input logic              win_fail,
    input logic [SKIP_W-1:0] skip_cnt
);
    p_never_veto_r5: assert property (@(posedge clk) disable iff (!rst_n)
        query_never |-> !allow);

    p_skip_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_cnt != '0) |-> !allow);

    p_no_query_no_allow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |-> !allow);

    p_fail_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_fail |=> (skip_cnt == SKIP_W'(SKIP_M)));

    p_skip_counts_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (query_valid && skip_cnt != '0 && !win_fail) |=> (skip_cnt == $past(skip_cnt) - SKIP_W'(1)));

    p_skip_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!query_valid && !win_fail) |=> $stable(skip_cnt));

    p_skip_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_cnt <= SKIP_W'(SKIP_M));
endmodule

bind ra_useful_gate ra_useful_gate_chk #(.SKIP_M(SKIP_M), .SKIP_W(SKIP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .query_valid (query_valid),
    .query_never (query_never),
    .allow       (allow),
    .win_fail    (win_fail),
    .skip_cnt    (skip_cnt)
);

// File: tb/sim_ra_useful_gate.sv
module sim_ra_useful_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        query_valid = 1'b0;
    logic [31:0] query_pc = '0;
    logic        query_never = 1'b0;
    logic        allow;
    logic        train_valid = 1'b0;
    logic [31:0] train_pc = '0;
    logic        train_useful = 1'b0;
    logic [7:0]  train_misses = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  e;
        string tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [31:0] PC_A  = 32'h0000_0104; // index 1
    localparam logic [31:0] PC_A2 = 32'h0000_0204; // index 1 (alias)
    localparam logic [31:0] PC_B  = 32'h0000_0108; // index 2

    always #2 clk = ~clk;

    ra_useful_gate u0 (
        .clk(clk), .rst_n(rst_n),
        .query_valid(query_valid), .query_pc(query_pc), .query_never(query_never),
        .allow(allow),
        .train_valid(train_valid), .train_pc(train_pc),
        .train_useful(train_useful), .train_misses(train_misses)
    );

    task automatic step(input logic qv, input logic [31:0] qpc, input logic qn,
                        input logic ex, input string tag,
                        input logic tv, input logic [31:0] tpc, input logic tu,
                        input logic [7:0] tm);
        exp_t it;
        @(negedge clk);
        query_valid  = qv;
        query_pc     = qpc;
        query_never  = qn;
        train_valid  = tv;
        train_pc     = tpc;
        train_useful = tu;
        train_misses = tm;
        if (qv) begin
            it.e   = ex;
            it.tag = tag;
            sb.push_back(it);
        end
    endtask

    task automatic q(input logic [31:0] pc, input logic nv, input logic ex, input string tag);
        step(1'b1, pc, nv, ex, tag, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t(input logic [31:0] pc, input logic u, input logic [7:0] m);
        step(1'b0, '0, 1'b0, 1'b0, "", 1'b1, pc, u, m);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            if (query_valid && rst_n) begin
                tests++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard empty: actual=%0b expected=<none>", allow);
                end else begin
                    it = sb.pop_front();
                    if (allow !== it.e) begin
                        fails++;
                        $display("FAIL %s: actual=%0b expected=%0b", it.tag, allow, it.e);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state is weakly useful and not skipping
        q(PC_A, 1'b0, 1'b1, "R2 reset allow");
        // R5: profile veto on a useful entry
        q(PC_B, 1'b1, 1'b0, "R5 never bit");
        // window 1: misses kept high so it passes
        t(PC_A, 1'b0, 8'd5);                       // A: 10->01
        q(PC_A, 1'b0, 1'b0, "R10 train visible next cycle");
        q(PC_A2, 1'b0, 1'b0, "R1 alias shares entry");
        q(PC_B, 1'b0, 1'b1, "R1 other index untouched");
        t(PC_A, 1'b0, 8'd5);                       // 00
        t(PC_A, 1'b0, 8'd5);                       // stays 00
        t(PC_A, 1'b1, 8'd5);                       // 01, window closes sum 20
        q(PC_A, 1'b0, 1'b0, "R3 counter 01 predicts useless");
        t(PC_A, 1'b1, 8'd5);                       // 10, window 2 pulse 1
        q(PC_A, 1'b0, 1'b1, "R3 low saturation then climb");
        t(PC_B, 1'b1, 8'd5);                       // B 11
        t(PC_B, 1'b1, 8'd5);                       // B 11 sat
        t(PC_B, 1'b1, 8'd5);                       // B 11 sat, window 2 passes
        t(PC_B, 1'b0, 8'd0);                       // B 10, window 3 pulse 1
        q(PC_B, 1'b0, 1'b1, "R3 high saturation");
        q(PC_B, 1'b1, 1'b0, "R4 veto with useful counter");
        // R8: same-cycle train and query on A (currently 10)
        step(1'b1, PC_A, 1'b0, 1'b1, "R8 query sees old value",
             1'b1, PC_A, 1'b0, 8'd0);               // A 01, pulse 2
        q(PC_A, 1'b0, 1'b0, "R8 update seen after");
        t(PC_A, 1'b1, 8'd0);                       // A 10, pulse 3
        t(PC_B, 1'b1, 8'd1);                       // pulse 4, sum 1 < 3 -> skip 5
        q(PC_B, 1'b0, 1'b0, "R6 failing window suppresses");
        q(PC_B, 1'b0, 1'b0, "R7 denied 2");
        t(PC_B, 1'b1, 8'd1);                       // window 4 pulse 1, no decrement
        q(PC_B, 1'b0, 1'b0, "R7 train does not decrement 3");
        q(PC_B, 1'b0, 1'b0, "R7 denied 4");
        q(PC_B, 1'b0, 1'b0, "R7 denied 5");
        q(PC_B, 1'b0, 1'b1, "R7 allowed after SKIP_M");
        // R6 boundary: sum exactly equal to threshold passes
        t(PC_B, 1'b1, 8'd1);
        t(PC_B, 1'b1, 8'd1);
        t(PC_B, 1'b1, 8'd0);                       // sum 3 == T
        q(PC_B, 1'b0, 1'b1, "R6 sum equal to threshold passes");
        // R9: failing window closes in the same cycle as a query
        t(PC_B, 1'b1, 8'd0);
        t(PC_B, 1'b1, 8'd0);
        t(PC_B, 1'b1, 8'd0);
        step(1'b1, PC_B, 1'b0, 1'b1, "R9 query during closing cycle",
             1'b1, PC_B, 1'b1, 8'd0);
        q(PC_B, 1'b0, 1'b0, "R9 denied 1");
        q(PC_B, 1'b0, 1'b0, "R9 denied 2");
        q(PC_B, 1'b0, 1'b0, "R9 denied 3");
        q(PC_B, 1'b0, 1'b0, "R9 denied 4");
        q(PC_B, 1'b0, 1'b0, "R9 load wins, denied 5");
        q(PC_B, 1'b0, 1'b1, "R9 allowed after full skip");
        step(1'b0, '0, 1'b0, 1'b0, "", 1'b0, '0, 1'b0, '0);
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule